// File: doc/BRIEF.md
# CAN Receive Mailbox Router

This block sits behind a CAN protocol engine. The engine hands it each frame that has been fully received and checked, as a one-cycle pulse carrying an 11-bit identifier, a length code and eight data bytes. The router decides which message object keeps the frame. It then shows the CPU, through a small read port, which objects hold data, which want service and which have lost a frame.

Each mailbox has a service mode:
- **Single-buffer matched mode** keeps the most recent frame whose identifier passes the mailbox's value and mask. It raises an interrupt for every frame it accepts.
- **Queued matched mode** holds several frames with the same identifier, in arrival order. Its interrupt waits until a set number of frames has built up.
- **Catch-all mode** keeps any frame that no matched mailbox took, so that software can filter it.

A matched mailbox can also require the first two data bytes to equal a filter value. The configuration comes in on static input vectors. The CPU selects a mailbox, reads the head entry from combinational outputs, and pulses a read strobe to consume that entry.

Top module: `can_rx_router`

## Requirements
- R1: After reset, every bit of `mb_pend`, `mb_irq` and `mb_lost` is 0.
- R2: Mailbox i is enabled when `cfg_en[i]` is 1. Its mode is `cfg_mode[2i+1:2i]`: 0 means catch-all, 1 means single-buffer matched, 2 means queued matched and 3 means unused. An enabled matched mailbox accepts a frame when `((in_id ^ id_i) & mask_i) == 0`. An accepted frame appears on `rd_id`/`rd_dlc`/`rd_data` for `rd_sel = i` in the cycle after the input pulse. A single-buffer mailbox sets `mb_pend[i]` and `mb_irq[i]` at the same time.
- R3: When several matched mailboxes accept the same frame, only the lowest-numbered one stores it.
- R4: A frame that no matched mailbox accepts goes to the lowest-numbered enabled catch-all mailbox. If there is no such mailbox, the frame is dropped and no mailbox changes.
- R5: A frame that reaches a single-buffer or catch-all mailbox that still holds an unread frame replaces the old contents and sets `mb_lost[i]`. A read with `rd_en` clears `mb_pend[i]`, `mb_irq[i]` and `mb_lost[i]`.
- R6: A queued mailbox stores up to `FIFO_DEPTH` (4) frames. Reads return them in arrival order.
- R7: A queued mailbox raises `mb_irq[i]` only while it holds at least `IRQ_LEVEL` (4) frames. `mb_pend[i]` is 1 while it holds any frame.
- R8: A frame that arrives at a full queued mailbox, with no read in the same cycle, is discarded and sets `mb_lost[i]`. The next read clears the flag.
- R9: When `cfg_dchk[i]` is 1, the frame must also satisfy `in_dlc >= 2`, byte 0 (`in_data[7:0]`) equal to `cfg_dval[16i+7:16i]`, and byte 1 (`in_data[15:8]`) equal to `cfg_dval[16i+15:16i+8]`. A frame that fails this test falls through to the catch-all path.
- R10: A mailbox with `cfg_en[i]` equal to 0 never receives a frame, whatever its identifier settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | One-cycle pulse for a received frame |
| in_id | input | 11 | Frame identifier |
| in_dlc | input | 4 | Frame length code |
| in_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| cfg_en | input | NUM_MB | Per-mailbox enable |
| cfg_mode | input | 2*NUM_MB | Per-mailbox mode code |
| cfg_id | input | 11*NUM_MB | Per-mailbox identifier value |
| cfg_mask | input | 11*NUM_MB | Per-mailbox identifier mask, 1 = compare the bit |
| cfg_dchk | input | NUM_MB | Per-mailbox data-byte filter enable |
| cfg_dval | input | 16*NUM_MB | Per-mailbox filter value for data bytes 0 and 1 |
| rd_sel | input | SEL_W | Mailbox that the read port shows |
| rd_en | input | 1 | Consume the head entry of the selected mailbox |
| rd_id | output | 11 | Head identifier of the selected mailbox |
| rd_dlc | output | 4 | Head length code of the selected mailbox |
| rd_data | output | 64 | Head data of the selected mailbox |
| mb_pend | output | NUM_MB | Mailbox holds at least one frame |
| mb_irq | output | NUM_MB | Mailbox service request |
| mb_lost | output | NUM_MB | Frame lost to an overwrite or a full queue |

## Verification
The hardest state to reach is a full queued mailbox that receives a fifth frame. Only four back-to-back matching frames with no read in between produce it. The same sequence also has to show that the interrupt stays low for the first three frames. The bench drives exactly that burst, then a fifth frame, then drains the queue to prove that the dropped frame never appears and that the order is kept. Priority and fall-through are forced with one pair of overlapping filters. That pair differs only in the mask width and the data-byte test, so one identifier can be steered to three different mailboxes by changing only the data bytes, the length code or an enable.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ID_W   = 11;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int DVAL_W = 16;

  typedef enum logic [1:0] {
    MB_CATCH  = 2'd0,
    MB_SINGLE = 2'd1,
    MB_QUEUE  = 2'd2,
    MB_UNUSED = 2'd3
  } mb_mode_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rx_frame_t;

  function automatic logic id_pass(input logic [ID_W-1:0] id,
                                   input logic [ID_W-1:0] ref_id,
                                   input logic [ID_W-1:0] mask);
    return ((id ^ ref_id) & mask) == '0;
  endfunction

  function automatic logic data_pass(input rx_frame_t f, input logic chk,
                                     input logic [DVAL_W-1:0] val);
    return !chk || ((f.dlc >= DLC_W'(2)) && (f.data[DVAL_W-1:0] == val));
  endfunction
endpackage

// File: rtl/can_rx_match.sv
module can_rx_match
  import can_rx_pkg::*;
#(
  parameter int NUM_MB = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  rx_frame_t                frame,
  input  logic [NUM_MB-1:0]        cfg_en,
  input  logic [2*NUM_MB-1:0]      cfg_mode,
  input  logic [ID_W*NUM_MB-1:0]   cfg_id,
  input  logic [ID_W*NUM_MB-1:0]   cfg_mask,
  input  logic [NUM_MB-1:0]        cfg_dchk,
  input  logic [DVAL_W*NUM_MB-1:0] cfg_dval,
  output logic [NUM_MB-1:0]        sel
);
  logic [NUM_MB-1:0] hit;
  logic [NUM_MB-1:0] catcher;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_cmp
    mb_mode_e m;
    assign m = mb_mode_e'(cfg_mode[2*i +: 2]);
    assign hit[i] = cfg_en[i] && (m == MB_SINGLE || m == MB_QUEUE)
                    && id_pass(frame.id, cfg_id[ID_W*i +: ID_W], cfg_mask[ID_W*i +: ID_W])
                    && data_pass(frame, cfg_dchk[i], cfg_dval[DVAL_W*i +: DVAL_W]);
    assign catcher[i] = cfg_en[i] && (m == MB_CATCH);

    if (i > 0) begin : g_prio
      // R3: a winner never has a lower-numbered matching mailbox
      a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel[i] && hit[i]) |-> (hit[i-1:0] == '0));
    end
  end

  always_comb begin
    logic taken;
    sel   = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (hit[i] && !taken) begin
        sel[i] = in_valid;
        taken  = 1'b1;
      end
    end
    for (int i = 0; i < NUM_MB; i++) begin
      if (catcher[i] && !taken) begin
        sel[i] = in_valid;
        taken  = 1'b1;
      end
    end
  end

  // R2: at most one mailbox takes a frame
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
  // R4: catch-all path only when nothing matched
  a_r4_catch_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel & ~hit) != '0) |-> (hit == '0));
  // R10: disabled mailboxes never selected
  a_r10_no_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (sel & ~cfg_en) == '0);
endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
  import can_rx_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int IRQ_LEVEL = 4,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  mb_mode_e  mode,
  input  logic      wr,
  input  rx_frame_t wr_frame,
  input  logic      pop,
  output rx_frame_t head,
  output logic      pend,
  output logic      irq,
  output logic      lost
);
  rx_frame_t        mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  logic single, queued, is_full, do_pop, push_ok, drop, overwrite;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign single    = (mode == MB_SINGLE) || (mode == MB_CATCH);
  assign queued    = (mode == MB_QUEUE);
  assign is_full   = (count == CNT_W'(DEPTH));
  assign do_pop    = pop && (count != '0);
  assign push_ok   = queued && wr && (!is_full || do_pop);
  assign drop      = queued && wr && is_full && !do_pop;
  assign overwrite = single && wr && (count != '0) && !do_pop;

  always_ff @(posedge clk) begin
    if (single && wr)   mem[rd_ptr] <= wr_frame;
    else if (push_ok)   mem[wr_ptr] <= wr_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      lost   <= 1'b0;
    end else if (single) begin
      if (wr)          count <= CNT_W'(1);
      else if (do_pop) count <= '0;
      if (do_pop)         lost <= 1'b0;
      else if (overwrite) lost <= 1'b1;
    end else if (queued) begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(do_pop);
      if (drop)        lost <= 1'b1;
      else if (do_pop) lost <= 1'b0;
    end
  end

  assign head = mem[rd_ptr];
  assign pend = (count != '0);
  assign irq  = queued ? (count >= CNT_W'(IRQ_LEVEL)) : (single && pend);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r5_single_holds_one: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> (count <= CNT_W'(1)));
  a_r5_overwrite_flags: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite |=> lost);
  a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ($stable(count) && lost));
  a_r7_irq_at_level: assert property (@(posedge clk) disable iff (!rst_n)
    (queued && $rose(irq)) |-> (count == CNT_W'(IRQ_LEVEL)));
endmodule

// File: rtl/can_rx_router.sv
module can_rx_router
  import can_rx_pkg::*;
#(
  parameter int NUM_MB     = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int IRQ_LEVEL  = 4,
  localparam int SEL_W     = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [10:0]              in_id,
  input  logic [3:0]               in_dlc,
  input  logic [63:0]              in_data,
  input  logic [NUM_MB-1:0]        cfg_en,
  input  logic [2*NUM_MB-1:0]      cfg_mode,
  input  logic [11*NUM_MB-1:0]     cfg_id,
  input  logic [11*NUM_MB-1:0]     cfg_mask,
  input  logic [NUM_MB-1:0]        cfg_dchk,
  input  logic [16*NUM_MB-1:0]     cfg_dval,
  input  logic [SEL_W-1:0]         rd_sel,
  input  logic                     rd_en,
  output logic [10:0]              rd_id,
  output logic [3:0]               rd_dlc,
  output logic [63:0]              rd_data,
  output logic [NUM_MB-1:0]        mb_pend,
  output logic [NUM_MB-1:0]        mb_irq,
  output logic [NUM_MB-1:0]        mb_lost
);
  rx_frame_t         frame;
  rx_frame_t         heads [NUM_MB];
  logic [NUM_MB-1:0] sel;

  assign frame = '{id: in_id, dlc: in_dlc, data: in_data};

  can_rx_match #(.NUM_MB(NUM_MB)) u_match (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame(frame),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_id(cfg_id), .cfg_mask(cfg_mask),
    .cfg_dchk(cfg_dchk), .cfg_dval(cfg_dval), .sel(sel)
  );

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic pop_i;
    assign pop_i = rd_en && (rd_sel == SEL_W'(i));
    can_rx_mailbox #(.DEPTH(FIFO_DEPTH), .IRQ_LEVEL(IRQ_LEVEL)) u_mb (
      .clk(clk), .rst_n(rst_n), .mode(mb_mode_e'(cfg_mode[2*i +: 2])),
      .wr(sel[i]), .wr_frame(frame), .pop(pop_i), .head(heads[i]),
      .pend(mb_pend[i]), .irq(mb_irq[i]), .lost(mb_lost[i])
    );
  end

  always_comb begin
    rd_id   = '0;
    rd_dlc  = '0;
    rd_data = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_id   = heads[i].id;
        rd_dlc  = heads[i].dlc;
        rd_data = heads[i].data;
      end
    end
  end

  // R1: flags stay clear through reset release
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (mb_pend == '0 && mb_lost == '0));
endmodule

// File: tb/can_rx_router_bench.sv
module can_rx_router_bench;
  localparam int NMB = 4;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [10:0] in_id = 0;
  logic [3:0] in_dlc = 0;
  logic [63:0] in_data = 0;
  logic [NMB-1:0] cfg_en, cfg_dchk;
  logic [2*NMB-1:0] cfg_mode;
  logic [11*NMB-1:0] cfg_id, cfg_mask;
  logic [16*NMB-1:0] cfg_dval;
  logic [1:0] rd_sel = 0;
  logic rd_en = 0;
  logic [10:0] rd_id;
  logic [3:0] rd_dlc;
  logic [63:0] rd_data;
  logic [NMB-1:0] mb_pend, mb_irq, mb_lost;

  int errors = 0, checks = 0;
  logic [78:0] exp_q [NMB][$];
  logic [NMB-1:0] exp_lost = '0;
  int mode_b [NMB] = '{1, 2, 0, 1};

  always #2 clk = ~clk;

  can_rx_router u_can_rx_router (.*);

  task automatic chk(input string tag, input logic [78:0] act, input logic [78:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: pushes the expected result into the scoreboard
  task automatic send(input logic [10:0] id, input logic [3:0] dlc,
                      input logic [63:0] d, input int mb);
    @(negedge clk);
    in_valid = 1; in_id = id; in_dlc = dlc; in_data = d;
    if (mb >= 0) begin
      if (mode_b[mb] != 2) begin
        if (exp_q[mb].size() > 0) begin exp_lost[mb] = 1; exp_q[mb].delete(); end
        exp_q[mb].push_back({id, dlc, d});
      end else if (exp_q[mb].size() < 4) exp_q[mb].push_back({id, dlc, d});
      else exp_lost[mb] = 1;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor: pops the expected head and compares with the read port
  task automatic take(input int mb, input string tag);
    logic [78:0] e;
    @(negedge clk);
    rd_sel = mb[1:0];
    #1;
    chk({tag, " pend"}, 79'(mb_pend[mb]), 79'(exp_q[mb].size() > 0));
    chk({tag, " lost"}, 79'(mb_lost[mb]), 79'(exp_lost[mb]));
    e = (exp_q[mb].size() > 0) ? exp_q[mb].pop_front() : 'x;
    chk({tag, " head"}, {rd_id, rd_dlc, rd_data}, e);
    exp_lost[mb] = 0;
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cfg_en = 4'b1111;
    cfg_mode = {2'd1, 2'd0, 2'd2, 2'd1};
    cfg_id = {11'h250, 11'h000, 11'h3FF, 11'h250};
    cfg_mask = {11'h7F0, 11'h000, 11'h7FF, 11'h7FF};
    cfg_dchk = 4'b1000;
    cfg_dval = {16'hBEEF, 16'h0, 16'h0, 16'h0};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pend", 79'(mb_pend), 0);
    chk("R1 irq", 79'(mb_irq), 0);
    chk("R1 lost", 79'(mb_lost), 0);
    rst_n = 1;
    // R2 basic single-buffer match
    send(11'h250, 4'd8, 64'h1122334455667788, 0);
    chk("R2 irq", 79'(mb_irq), 79'(4'b0001));
    take(0, "R2");
    chk("R2 cleared", 79'(mb_pend[0]), 0);
    // R5 overwrite
    send(11'h250, 4'd3, 64'hAAA, 0);
    send(11'h250, 4'd4, 64'hBBB, 0);
    take(0, "R5");
    chk("R5 lost cleared", 79'(mb_lost[0]), 0);
    chk("R5 irq cleared", 79'(mb_irq[0]), 0);
    // R6/R7/R8 queue
    for (int k = 0; k < 3; k++) send(11'h3FF, 4'd8, 64'h100 + 64'(k), 1);
    chk("R7 no irq at 3", 79'(mb_irq[1]), 0);
    chk("R7 pend at 3", 79'(mb_pend[1]), 1);
    send(11'h3FF, 4'd8, 64'h103, 1);
    chk("R7 irq at 4", 79'(mb_irq[1]), 1);
    send(11'h3FF, 4'd8, 64'h104, 1);
    chk("R8 overflow", 79'(mb_lost[1]), 1);
    take(1, "R6 first");
    chk("R7 irq drops", 79'(mb_irq[1]), 0);
    for (int k = 0; k < 3; k++) take(1, "R6 order");
    chk("R8 empty", 79'(mb_pend[1]), 0);
    // R3 priority: matches mb0 and mb3
    send(11'h250, 4'd8, 64'hBEEF, 0);
    chk("R3 mb3 untouched", 79'(mb_pend[3]), 0);
    take(0, "R3");
    // R9 data filter
    send(11'h255, 4'd2, 64'hBEEF, 3);
    take(3, "R9 pass");
    send(11'h255, 4'd8, 64'h0000, 2);
    take(2, "R9 bytes differ");
    send(11'h255, 4'd1, 64'hBEEF, 2);
    chk("R9 short dlc", 79'(mb_pend[3]), 0);
    take(2, "R9 short");
    // R4 unmatched to catch-all
    send(11'h100, 4'd5, 64'h55, 2);
    take(2, "R4 catch");
    // R10 disabled
    @(negedge clk); cfg_en[3] = 0;
    send(11'h255, 4'd2, 64'hBEEF, 2);
    chk("R10 disabled", 79'(mb_pend[3]), 0);
    take(2, "R10");
    // R4 drop when no catch-all
    @(negedge clk); cfg_en[2] = 0;
    send(11'h100, 4'd5, 64'h66, -1);
    chk("R4 dropped", 79'(mb_pend), 0);
    finish_run();
  end
endmodule